// File: doc/BRIEF.md
# Delta-Modulation Sample Voice

This block turns a stream of 1-bit delta codes into a 7-bit audio level. A programmable countdown timer, advanced by a clock enable that pulses once per CPU cycle, sets how often the output steps. Each time the timer expires, the block takes one bit from an 8-bit shift register. It moves the level up or down by two according to that bit, and it stops at either end of the range.

Bytes reach the shift register through a one-byte holding buffer. An external fetch engine fills the buffer with a load strobe. The buffer-empty output tells that engine when it may send the next byte. At each byte boundary the buffered byte moves into the shift register. If no byte is waiting at a boundary, the block mutes for the next eight steps and holds the level where it is.

A direct write can set the level to any value at any time. Software uses it to position the waveform or to play raw PCM. Fetching from memory, interrupts and mixing are handled by the blocks around this one.

Top module: `dpcm_voice`

## Requirements
- R1: With `region` equal to 0, 2 or 3, rate indices 0 to 15 give periods of 428, 380, 340, 320, 286, 254, 226, 214, 190, 160, 142, 128, 106, 84, 72 and 54 enabled cycles.
- R2: With `region` equal to 1, rate indices 0 to 15 give periods of 398, 354, 316, 298, 276, 236, 210, 198, 176, 148, 132, 118, 98, 78, 66 and 50 enabled cycles.
- R3: The timer changes only on cycles where `tick` is 1. On such a cycle it counts down by one, or, if it already reads zero, it reloads with period−1 and issues one output step. Steps therefore come exactly once every period ticks.
- R4: Synchronous reset gives level 0, the buffer empty (`buf_empty`=1), the output muted, 8 bits remaining in the current byte, and the timer at period−1 for rate index 0 of the selected region.
- R5: A change to `rate` or `region` affects only the next reload value. It does not disturb a count already in progress.
- R6: On an unmuted step whose current bit is 1, the level rises by 2 if it is at most 125. At 126 or 127 it stays where it is.
- R7: On an unmuted step whose current bit is 0, the level falls by 2 if it is at least 2. At 0 or 1 it stays where it is.
- R8: Every step shifts the register right by one, so each byte is played LSB first over eight steps.
- R9: On the eighth step of a byte, a full buffer moves into the shift register, the buffer becomes empty and muting is cleared.
- R10: If the buffer is empty on the eighth step, the next eight steps are muted and the level does not change during them.
- R11: A write with `lvl_wr` sets the level to bits 6:0 of `lvl_wdata` on the next clock edge.
- R12: A `buf_load` while the buffer is full is ignored, and the byte already held is kept.
- R13: If a direct write and a step fall on the same cycle, the level takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Clock enable for the timer, one pulse per CPU cycle |
| rate | input | 4 | Rate index that selects the reload period |
| region | input | 2 | Period table select: 1 for the alternate table, any other value for the primary table |
| lvl_wr | input | 1 | Direct level write strobe |
| lvl_wdata | input | 8 | Direct write data; only bits 6:0 are used |
| buf_load | input | 1 | Strobe that loads a byte into the holding buffer |
| buf_data | input | 8 | Byte to load into the buffer |
| level | output | 7 | Current output level, 0 to 127 |
| buf_empty | output | 1 | High while the holding buffer has no byte |

## Verification
A timer phase that is off by even one cycle moves every later step. The level then changes on the wrong cycle, and a cycle-by-cycle comparison catches it on the first step after the error. A wrong bit counter or muting flag has a different signature: the level keeps moving when it should freeze, or stays frozen when it should move, and `buf_empty` rises at the wrong byte boundary. Such errors appear within one byte period at most, which is eight steps. Buffer errors appear one byte later, when a byte that should have been dropped is played or a byte that should have been kept is lost.

// File: rtl/dpcm_pkg.sv
package dpcm_pkg;

    localparam int PER_W   = 9;
    localparam int LVL_W   = 7;
    localparam int BYTE_W  = 8;
    localparam int BCNT_W  = 4;
    localparam int RATE_W  = 4;
    localparam int REG_W   = 2;
    localparam int STEP    = 2;

    typedef enum logic [REG_W-1:0] {
        REG_MAIN  = 2'd0,
        REG_ALT   = 2'd1,
        REG_THIRD = 2'd2,
        REG_SPARE = 2'd3
    } region_e;

    typedef struct packed {
        logic [BYTE_W-1:0] sh;
        logic [BCNT_W-1:0] bits;
        logic              muted;
        logic [BYTE_W-1:0] hold;
        logic              full;
    } shift_st_t;

    function automatic logic [PER_W-1:0] main_period(input logic [RATE_W-1:0] i);
        case (i)
            4'd0:  return 9'd428;
            4'd1:  return 9'd380;
            4'd2:  return 9'd340;
            4'd3:  return 9'd320;
            4'd4:  return 9'd286;
            4'd5:  return 9'd254;
            4'd6:  return 9'd226;
            4'd7:  return 9'd214;
            4'd8:  return 9'd190;
            4'd9:  return 9'd160;
            4'd10: return 9'd142;
            4'd11: return 9'd128;
            4'd12: return 9'd106;
            4'd13: return 9'd84;
            4'd14: return 9'd72;
            default: return 9'd54;
        endcase
    endfunction

    function automatic logic [PER_W-1:0] alt_period(input logic [RATE_W-1:0] i);
        case (i)
            4'd0:  return 9'd398;
            4'd1:  return 9'd354;
            4'd2:  return 9'd316;
            4'd3:  return 9'd298;
            4'd4:  return 9'd276;
            4'd5:  return 9'd236;
            4'd6:  return 9'd210;
            4'd7:  return 9'd198;
            4'd8:  return 9'd176;
            4'd9:  return 9'd148;
            4'd10: return 9'd132;
            4'd11: return 9'd118;
            4'd12: return 9'd98;
            4'd13: return 9'd78;
            4'd14: return 9'd66;
            default: return 9'd50;
        endcase
    endfunction

    function automatic logic [PER_W-1:0] period_of(input region_e r,
                                                   input logic [RATE_W-1:0] i);
        return (r == REG_ALT) ? alt_period(i) : main_period(i);
    endfunction

endpackage

// File: rtl/dpcm_rate_timer.sv
module dpcm_rate_timer
    import dpcm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [RATE_W-1:0] rate,
    input  logic [REG_W-1:0]  region,
    output logic              fire
);
    localparam logic [PER_W-1:0] ONE = PER_W'(1);

    logic [PER_W-1:0] cnt;
    logic [PER_W-1:0] reload;
    logic [PER_W-1:0] boot;

    always_comb begin
        reload = period_of(region_e'(region), rate) - ONE;
        boot   = period_of(region_e'(region), '0) - ONE;
        fire   = tick && (cnt == '0);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= boot;
        else if (tick)
            cnt <= (cnt == '0) ? reload : cnt - ONE;
    end

    // R3: an expiry reloads the count from the period in force at that edge
    a_r3_reload: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt == '0) |=> (cnt == $past(reload)));

    // R3: without a tick the count does not move
    a_r3_idle: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt));

endmodule

// File: rtl/dpcm_bit_shifter.sv
module dpcm_bit_shifter
    import dpcm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic              load,
    input  logic [BYTE_W-1:0] din,
    output logic              cur_bit,
    output logic              muted,
    output logic              full
);
    localparam logic [BCNT_W-1:0] BITS_PER = BCNT_W'(BYTE_W);
    localparam logic [BCNT_W-1:0] B_ONE    = BCNT_W'(1);

    shift_st_t st, nx;

    always_comb begin
        nx = st;
        if (fire) begin
            nx.sh = st.sh >> 1;
            if (st.bits == B_ONE) begin
                nx.bits = BITS_PER;
                if (st.full) begin
                    nx.sh    = st.hold;
                    nx.full  = 1'b0;
                    nx.muted = 1'b0;
                end else begin
                    nx.muted = 1'b1;
                end
            end else begin
                nx.bits = st.bits - B_ONE;
            end
        end
        if (load && !st.full) begin
            nx.hold = din;
            nx.full = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st.sh    <= '0;
            st.bits  <= BITS_PER;
            st.muted <= 1'b1;
            st.hold  <= '0;
            st.full  <= 1'b0;
        end else begin
            st <= nx;
        end
    end

    assign cur_bit = st.sh[0];
    assign muted   = st.muted;
    assign full    = st.full;

    // R12: a load into a full buffer that is not being drained keeps the held byte
    a_r12_keep_full: assert property (@(posedge clk) disable iff (rst)
        (load && st.full && !fire) |=> (st.full && $stable(st.hold)));

    // R8: the bit counter stays within one byte
    a_r8_bits_range: assert property (@(posedge clk) disable iff (rst)
        (st.bits >= B_ONE) && (st.bits <= BITS_PER));

    // R10: a boundary with an empty buffer mutes the following byte
    a_r10_mute: assert property (@(posedge clk) disable iff (rst)
        (fire && st.bits == B_ONE && !st.full) |=> st.muted);

endmodule

// File: rtl/dpcm_level_unit.sv
module dpcm_level_unit
    import dpcm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             step_en,
    input  logic             up,
    input  logic             wr_en,
    input  logic [LVL_W-1:0] wr_val,
    output logic [LVL_W-1:0] lvl
);
    localparam logic [LVL_W-1:0] STEP_V  = LVL_W'(STEP);
    localparam logic [LVL_W-1:0] UP_LIM  = LVL_W'((1 << LVL_W) - 1 - STEP);

    logic [LVL_W-1:0] nxt;

    always_comb begin
        nxt = lvl;
        if (wr_en)
            nxt = wr_val;
        else if (step_en) begin
            if (up && lvl <= UP_LIM)
                nxt = lvl + STEP_V;
            else if (!up && lvl >= STEP_V)
                nxt = lvl - STEP_V;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) lvl <= '0;
        else     lvl <= nxt;
    end

    // R6: no rise past the top of the range
    a_r6_top_hold: assert property (@(posedge clk) disable iff (rst)
        (step_en && up && !wr_en && lvl > UP_LIM) |=> $stable(lvl));

    // R7: no fall past the bottom of the range
    a_r7_floor_hold: assert property (@(posedge clk) disable iff (rst)
        (step_en && !up && !wr_en && lvl < STEP_V) |=> $stable(lvl));

    // R11, R13: a direct write wins over any step
    a_r13_write_wins: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (lvl == $past(wr_val)));

endmodule

// File: rtl/dpcm_voice.sv
module dpcm_voice
    import dpcm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [RATE_W-1:0] rate,
    input  logic [REG_W-1:0]  region,
    input  logic              lvl_wr,
    input  logic [BYTE_W-1:0] lvl_wdata,
    input  logic              buf_load,
    input  logic [BYTE_W-1:0] buf_data,
    output logic [LVL_W-1:0]  level,
    output logic              buf_empty
);
    logic fire;
    logic cur_bit;
    logic muted;
    logic full;

    dpcm_rate_timer u_timer (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .rate   (rate),
        .region (region),
        .fire   (fire)
    );

    dpcm_bit_shifter u_shift (
        .clk     (clk),
        .rst     (rst),
        .fire    (fire),
        .load    (buf_load),
        .din     (buf_data),
        .cur_bit (cur_bit),
        .muted   (muted),
        .full    (full)
    );

    dpcm_level_unit u_level (
        .clk     (clk),
        .rst     (rst),
        .step_en (fire && !muted),
        .up      (cur_bit),
        .wr_en   (lvl_wr),
        .wr_val  (lvl_wdata[LVL_W-1:0]),
        .lvl     (level)
    );

    assign buf_empty = !full;

    // R10: while muted, an expiry without a write leaves the level alone
    a_r10_frozen: assert property (@(posedge clk) disable iff (rst)
        (fire && muted && !lvl_wr) |=> $stable(level));

endmodule

// File: tb/tb_dpcm_voice.sv
module tb_dpcm_voice;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst, tick, lvl_wr, buf_ld;
    logic [3:0] rate;
    logic [1:0] region;
    logic [7:0] lvl_data, buf_dat;
    wire  [6:0] level;
    wire        buf_empty;

    dpcm_voice dut (
        .clk(clk), .rst(rst), .tick(tick), .rate(rate), .region(region),
        .lvl_wr(lvl_wr), .lvl_wdata(lvl_data), .buf_load(buf_ld),
        .buf_data(buf_dat), .level(level), .buf_empty(buf_empty)
    );

    int total = 0;
    int bad   = 0;
    int m_cnt, m_lvl, m_bits;
    logic [7:0] m_sh, m_hold;
    bit m_mute, m_full;

    function automatic int per(int r, int i);
        int a[16] = '{428, 380, 340, 320, 286, 254, 226, 214,
                      190, 160, 142, 128, 106, 84, 72, 54};
        int b[16] = '{398, 354, 316, 298, 276, 236, 210, 198,
                      176, 148, 132, 118, 98, 78, 66, 50};
        return (r == 1) ? b[i] : a[i];
    endfunction

    function automatic int step_lvl(int l, bit up);
        if (up)  return (l <= 125) ? l + 2 : l;
        return (l >= 2) ? l - 2 : l;
    endfunction

    task automatic chk(string tag, int got, int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_cnt  = per(int'(region), 0) - 1;
        m_lvl  = 0;
        m_bits = 8;
        m_mute = 1'b1;
        m_full = 1'b0;
        m_sh   = '0;
        m_hold = '0;
    endtask

    task automatic model_edge();
        bit fire;
        bit was_full;
        fire     = tick && (m_cnt == 0);
        was_full = m_full;
        if (tick) m_cnt = (m_cnt == 0) ? per(int'(region), int'(rate)) - 1 : m_cnt - 1;
        if (lvl_wr)               m_lvl = int'(lvl_data & 8'h7F);
        else if (fire && !m_mute) m_lvl = step_lvl(m_lvl, m_sh[0]);
        if (fire) begin
            m_sh = m_sh >> 1;
            if (m_bits == 1) begin
                m_bits = 8;
                if (was_full) begin
                    m_sh = m_hold; m_full = 1'b0; m_mute = 1'b0;
                end else m_mute = 1'b1;
            end else m_bits = m_bits - 1;
        end
        if (buf_ld && !was_full) begin
            m_hold = buf_dat; m_full = 1'b1;
        end
    endtask

    task automatic cyc(bit t, bit lw, logic [7:0] ld, bit bl, logic [7:0] bd, string tag);
        @(negedge clk);
        tick = t; lvl_wr = lw; lvl_data = ld; buf_ld = bl; buf_dat = bd;
        @(posedge clk);
        model_edge();
        #2;
        chk(tag, int'(level), m_lvl);
        chk(tag, int'(buf_empty), int'(!m_full));
    endtask

    task automatic do_reset(logic [1:0] r);
        @(negedge clk);
        rst = 1'b1; region = r; rate = 4'd0; tick = 1'b0;
        lvl_wr = 1'b0; buf_ld = 1'b0; lvl_data = '0; buf_dat = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        chk("R4", int'(level), 0);
        chk("R4", int'(buf_empty), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'd4711));
        rst = 1'b1;

        // Reset, then exact cadence on the primary table
        do_reset(2'd0);
        rate = 4'd15;
        cyc(1, 1, 8'hC0, 1, 8'h01, "R11");
        chk("R11", int'(level), 64);
        cyc(1, 0, 8'h00, 1, 8'hFE, "R12");
        n = 2;
        while (level == 7'd64 && n < 2000) begin
            n++;
            cyc(1, 0, 8'h00, 0, 8'h00, "R1");
            if (n == 806) chk("R9", int'(buf_empty), 1);
        end
        chk("R3", n, 860);
        chk("R12", int'(level), 66);
        repeat (1500) cyc(1, 0, 8'h00, 0, 8'h00, "R10");

        // Top saturation on the alternate table
        do_reset(2'd1);
        rate = 4'd15;
        cyc(1, 1, 8'h7D, 1, 8'hFF, "R6");
        repeat (3000) cyc(1, 0, 8'h00, 1, 8'hFF, "R2");
        chk("R6", int'(level), 127);

        // Bottom saturation
        rate = 4'd14; region = 2'd2;
        cyc(1, 1, 8'h81, 1, 8'h00, "R7");
        repeat (3000) cyc(1, 0, 8'h00, 1, 8'h00, "R7");
        chk("R7", int'(level), 1);

        // Rate changes mid-count
        for (int k = 0; k < 20; k++) begin
            rate = 4'($urandom_range(0, 15));
            repeat (37) cyc(1, 0, 8'h00, 1, 8'($urandom), "R5");
        end

        // Direct write on the same edge as an unmuted step
        cyc(1, 1, 8'd60, 1, 8'hAA, "R13");
        n = 0;
        while (!(m_cnt == 0 && !m_mute) && n < 6000) begin
            n++;
            cyc(1, 0, 8'h00, 1, 8'hAA, "R13");
        end
        cyc(1, 1, 8'h14, 0, 8'h00, "R13");
        chk("R13", int'(level), 20);

        // Constrained random traffic with gated ticks
        for (int i = 0; i < 20000; i++) begin
            bit dense;
            dense = ((i / 2000) % 2) == 0;
            if ((i % 700) == 0) begin
                rate   = 4'($urandom_range(0, 15));
                region = 2'($urandom_range(0, 3));
            end
            cyc(($urandom_range(0, 9) != 0),
                ($urandom_range(0, 399) == 0), 8'($urandom),
                dense ? ($urandom_range(0, 7) == 0) : ($urandom_range(0, 299) == 0),
                8'($urandom), "R8");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule